// File: doc/BRIEF.md
# Per-Block Write Protection Register

This block keeps one small protection register for each erase block of a flash array. Each register holds two software bits: a write-lock bit, which blocks program and erase on that block, and a lock-down bit. Once the lock-down bit is set, the register is frozen until reset. A host reaches the registers over a plain register bus. The bus has a block address, write data, a write strobe and combinational read data.

Two active-low protect inputs act on top of the software bits. One protects the highest-numbered block, the boot block. The other protects a fixed group of the lowest blocks. These inputs never appear in the readback value. The block also gives a per-block "program/erase allowed" vector. When an operation starts, the block samples the allowed state of the chosen block into a permit flag. That flag holds for the whole operation.

Top module: `blk_wprot`

## Requirements
- R1: After either reset input is asserted (low), every block register reads 0x01: write-lock set, lock-down clear. `op_permit` reads 0.
- R2: A write to an unfrozen block stores write data bit 0 as the write-lock bit and bit 1 as the lock-down bit. Readback bits 7:2 are always 0, whatever was written.
- R3: With both protect inputs high, `allowed[i]` is 1 exactly when the write-lock bit of block i is 0.
- R4: While a block's lock-down bit is 1, writes to that block's register change neither of its bits.
- R5: A lock-down bit returns to 0 only through `rst_n` or `init_n`. Either input alone restores every register to 0x01.
- R6: While `boot_prot_n` is low, `allowed[NBLK-1]` is 0, whatever the software bits say.
- R7: While `grp_prot_n` is low, `allowed[i]` is 0 for every block i below LOWGRP. Blocks at or above LOWGRP are unaffected, except that `boot_prot_n` still acts on the top block.
- R8: The readback value of every register is independent of `boot_prot_n` and `grp_prot_n`.
- R9: On a clock edge with `op_start` high, `op_permit` takes the value of `allowed[op_blk]` as it was before that edge. On edges without `op_start`, `op_permit` holds its value, even if locks or protect inputs change.
- R10: A register write on the same edge as `op_start` does not affect the sampled permit. The permit reflects the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up / hard reset) |
| init_n | input | 1 | Active-low asynchronous reset (secondary init) |
| reg_addr | input | AW | Block register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Readback of addressed register |
| boot_prot_n | input | 1 | Active-low protect for top boot block |
| grp_prot_n | input | 1 | Active-low protect for blocks 0..LOWGRP-1 |
| op_start | input | 1 | Program/erase start pulse |
| op_blk | input | AW | Target block of the starting operation |
| op_permit | output | 1 | Latched permission for the current operation |
| allowed | output | NBLK | Live per-block program/erase allowed |

## Verification
The bench builds the block with its defaults: sixteen blocks and a low protect group of seven. This gives three kinds of block: the group-protected blocks 0 to 6, the unprotected middle blocks 7 to 14, and the boot block 15. Each protect input can then be shown to spare the other kinds. With a four-bit address, random writes, reads and operation starts reach every register. Directed cases cover lock-down freezing, each reset input alone, and a write that lands on the same edge as an operation start.

// File: rtl/blk_wprot.sv
module blk_wprot #(
  parameter int NBLK   = 16,
  parameter int LOWGRP = 7,
  localparam int AW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic            reg_we,
  output logic [7:0]      reg_rdata,
  input  logic            boot_prot_n,
  input  logic            grp_prot_n,
  input  logic            op_start,
  input  logic [AW-1:0]   op_blk,
  output logic            op_permit,
  output logic [NBLK-1:0] allowed
);

  logic [NBLK-1:0] wl;
  logic [NBLK-1:0] ld;
  logic            arst_n;
  logic            addr_ok;
  logic            blk_ok;

  assign arst_n  = rst_n & init_n;
  assign addr_ok = 32'(reg_addr) < NBLK;
  assign blk_ok  = 32'(op_blk) < NBLK;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wl <= '1;
      ld <= '0;
    end else if (reg_we && addr_ok && !ld[reg_addr]) begin
      wl[reg_addr] <= reg_wdata[0];
      ld[reg_addr] <= reg_wdata[1];
    end
  end

  assign reg_rdata = addr_ok ? {6'b0, ld[reg_addr], wl[reg_addr]} : 8'h00;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic hw_prot;
    if (i == NBLK - 1 && i < LOWGRP) begin : g_both
      assign hw_prot = !boot_prot_n || !grp_prot_n;
    end else if (i == NBLK - 1) begin : g_boot
      assign hw_prot = !boot_prot_n;
    end else if (i < LOWGRP) begin : g_low
      assign hw_prot = !grp_prot_n;
    end else begin : g_free
      assign hw_prot = 1'b0;
    end
    assign allowed[i] = !wl[i] && !hw_prot;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       op_permit <= 1'b0;
    else if (op_start) op_permit <= blk_ok && allowed[op_blk];
  end

endmodule

module blk_wprot_chk #(
  parameter int NBLK   = 16,
  parameter int LOWGRP = 7,
  localparam int AW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_we,
  input logic [7:0]      reg_rdata,
  input logic            boot_prot_n,
  input logic            grp_prot_n,
  input logic            op_start,
  input logic [AW-1:0]   op_blk,
  input logic            op_permit,
  input logic [NBLK-1:0] allowed,
  input logic [NBLK-1:0] wl,
  input logic [NBLK-1:0] ld
);
  localparam int LG = (LOWGRP < NBLK) ? LOWGRP : NBLK;

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    reg_rdata[7:2] == 6'b0);

  assert_frozen_write_R4: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    (reg_we && reg_rdata[1]) |=> ($stable(wl) && $stable(ld)));

  assert_ldown_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    op_start || !op_start |=> (($past(ld) & ~ld) == '0));

  assert_boot_prot_R6: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    !boot_prot_n |-> !allowed[NBLK-1]);

  if (LG > 0) begin : g_lowchk
    assert_group_prot_R7: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
      !grp_prot_n |-> (allowed[LG-1:0] == '0));
  end

  assert_permit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    !op_start |=> $stable(op_permit));

  assert_permit_sample_R10: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    (op_start && 32'(op_blk) < NBLK) |=> (op_permit == $past(allowed[op_blk])));
endmodule

bind blk_wprot blk_wprot_chk #(.NBLK(NBLK), .LOWGRP(LOWGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_n(init_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .boot_prot_n(boot_prot_n), .grp_prot_n(grp_prot_n),
  .op_start(op_start), .op_blk(op_blk), .op_permit(op_permit), .allowed(allowed),
  .wl(wl), .ld(ld)
);

// File: tb/tb_blk_wprot.sv
module tb_blk_wprot;
  localparam int NBLK = 16;
  localparam int LOWGRP = 7;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, init_n = 1;
  logic [AW-1:0] reg_addr = '0, op_blk = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 0, boot_prot_n = 1, grp_prot_n = 1, op_start = 0, op_permit;
  logic [NBLK-1:0] allowed;

  logic [NBLK-1:0] m_wl, m_ld;
  logic m_permit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  blk_wprot #(.NBLK(NBLK), .LOWGRP(LOWGRP)) dut (.*);

  function automatic logic exp_allow(int b);
    logic hw;
    hw = (b == NBLK - 1 && !boot_prot_n) || (b < LOWGRP && !grp_prot_n);
    return !m_wl[b] && !hw;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wl = '1; m_ld = '0; m_permit = 0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    if (!m_ld[a]) begin m_wl[a] = d[0]; m_ld[a] = d[1]; end
  endtask

  task automatic rd(int a, string req);
    reg_addr = AW'(a); #1;
    chk(req, 32'(reg_rdata), {30'b0, m_ld[a], m_wl[a]});
  endtask

  task automatic chk_allow(string req);
    logic [NBLK-1:0] e;
    for (int b = 0; b < NBLK; b++) e[b] = exp_allow(b);
    chk(req, 32'(allowed), 32'(e));
  endtask

  task automatic op(int b, string req);
    @(negedge clk);
    op_blk = AW'(b); op_start = 1; m_permit = exp_allow(b);
    @(negedge clk);
    op_start = 0;
    chk(req, 32'(op_permit), 32'(m_permit));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int b = 0; b < NBLK; b++) rd(b, "R1");
    chk("R1", 32'(op_permit), 0);
    chk_allow("R1");

    wr(3, 8'hFC);
    rd(3, "R2");
    wr(9, 8'hFE);
    rd(9, "R2");
    chk_allow("R3");
    op(9, "R9");
    wr(9, 8'h01);
    boot_prot_n = 0; grp_prot_n = 0;
    @(negedge clk);
    chk("R9", 32'(op_permit), 32'(m_permit));
    boot_prot_n = 1; grp_prot_n = 1;

    for (int b = 0; b < NBLK; b++) wr(b, 8'h00);
    boot_prot_n = 0; #1; chk_allow("R6");
    rd(NBLK - 1, "R8");
    boot_prot_n = 1; grp_prot_n = 0; #1; chk_allow("R7");
    for (int b = 0; b < NBLK; b++) rd(b, "R8");
    op(2, "R7"); op(8, "R7");
    grp_prot_n = 1;

    wr(5, 8'h02);
    rd(5, "R4");
    wr(5, 8'h01);
    rd(5, "R4");
    wr(5, 8'h00);
    rd(5, "R4");
    op(5, "R4");

    @(negedge clk); init_n = 0; model_reset();
    @(negedge clk); init_n = 1;
    @(negedge clk);
    rd(5, "R5"); rd(0, "R5");
    chk("R5", 32'(op_permit), 0);
    wr(7, 8'h03);
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(7, "R5");

    wr(10, 8'h00);
    @(negedge clk);
    reg_addr = 4'd10; reg_wdata = 8'h01; reg_we = 1;
    op_blk = 4'd10; op_start = 1; m_permit = exp_allow(10);
    @(negedge clk);
    reg_we = 0; op_start = 0; m_wl[10] = 1'b1;
    chk("R10", 32'(op_permit), 32'(m_permit));
    rd(10, "R10");

    for (int i = 0; i < 400; i++) begin
      int k;
      int b;
      k = int'($urandom_range(0, 3));
      b = int'($urandom_range(0, NBLK - 1));
      boot_prot_n = ($urandom_range(0, 3) != 0);
      grp_prot_n  = ($urandom_range(0, 3) != 0);
      case (k)
        0: wr(b, 8'($urandom_range(0, 255) & 8'hFD | (($urandom_range(0, 15) == 0) ? 8'h02 : 8'h00)));
        1: rd(b, "R2");
        2: op(b, "R9");
        default: begin #1; chk_allow("R3"); end
      endcase
      if (i % 100 == 99) begin
        @(negedge clk); rst_n = 0; model_reset();
        @(negedge clk); rst_n = 1;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule